// File: doc/BRIEF.md
# Next Fetch Address Unit

This block owns the program counter of a simple in-order core. On every rising clock edge it loads the address of the next instruction to fetch. That address is one of three things: the current address plus four for straight-line code, a PC-relative target for conditional branches and direct jumps, or a register-relative target for indirect jumps. A synchronous reset loads a fixed start address. An interrupt request redirects fetch to a fixed service address. Both addresses are parameters.

The decoder supplies the kind of control transfer, the branch outcome, the relevant immediates, the first source operand and the destination register index. The block returns the current fetch address. For both jump kinds it also returns the return address (current PC plus four) together with a write enable for the register file. The enable is withheld when the destination is register zero, and when reset or an interrupt overrides the jump.

Top module: `npc_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `pc_q` loads `RESET_VEC` (default 0x0000_1000) at that edge.
- R2: With `xfer_kind` = 0 (sequential), `pc_q` advances by 4 at each edge, and `br_taken` has no effect.
- R3: With `xfer_kind` = 1 (conditional branch) and `br_taken` high, `pc_q` becomes `pc_q` plus the sign-extended 13-bit `br_off`, with bit 0 of `br_off` taken as zero. With `br_taken` low it advances by 4.
- R4: With `xfer_kind` = 2 (direct jump), `pc_q` becomes `pc_q` plus the sign-extended 21-bit `jmp_off`, with bit 0 of `jmp_off` taken as zero.
- R5: With `xfer_kind` = 3 (indirect jump), `pc_q` becomes `rs1_val` plus the sign-extended 12-bit `ind_imm`, with bit 0 of the sum cleared.
- R6: For `xfer_kind` 2 or 3 with `rd_idx` nonzero, `link_we` is 1 and `link_val` equals `pc_q` + 4 in the same cycle. Otherwise `link_we` is 0 and `link_val` is 0. In particular, `rd_idx` = 0 discards the link.
- R7: When `irq` is high and `rst` is low, `pc_q` loads `IRQ_VEC` (default 0x0000_0100) whatever the transfer kind, and `link_we` is 0.
- R8: Reset has priority over interrupt: with both high, `pc_q` loads `RESET_VEC` and `link_we` is 0.
- R9: All address arithmetic wraps modulo 2^32. For example, sequential flow from 0xFFFF_FFFC yields 0x0000_0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| irq | input | 1 | Interrupt request, redirects fetch |
| xfer_kind | input | 2 | 0 sequential, 1 branch, 2 direct jump, 3 indirect jump |
| br_taken | input | 1 | Branch outcome from the comparator |
| br_off | input | 13 | Branch offset, bit 0 ignored |
| jmp_off | input | 21 | Direct jump offset, bit 0 ignored |
| ind_imm | input | 12 | Indirect jump immediate |
| rs1_val | input | 32 | First source operand |
| rd_idx | input | 5 | Destination register index |
| pc_q | output | 32 | Current fetch address |
| link_we | output | 1 | Return address write enable |
| link_val | output | 32 | Return address (PC + 4) |

## Verification
The sequential and not-taken patterns distinguish a plain increment from a target add: a swapped select or a missing increment gives a different address. Branch and jump offsets at both signed extremes, and with bit 0 set, expose faulty sign extension or alignment. Odd indirect sums check the bit-0 clear. Interrupts and resets that coincide with jumps, and a long random stream compared each cycle against a behavioural model, separate priority errors from link-enable errors. A wrap from the top of the address space exercises modulo arithmetic.

// File: rtl/npc_pkg.sv
package npc_pkg;
  typedef enum logic [1:0] {
    XF_SEQ      = 2'd0,
    XF_BRANCH   = 2'd1,
    XF_JUMP     = 2'd2,
    XF_INDIRECT = 2'd3
  } xfer_e;
endpackage

// File: rtl/npc_targets.sv
module npc_targets #(
  parameter int XLEN  = 32,
  parameter int BR_W  = 13,
  parameter int JMP_W = 21,
  parameter int IND_W = 12
) (
  input  logic [XLEN-1:0]  pc,
  input  logic [BR_W-1:0]  br_off,
  input  logic [JMP_W-1:0] jmp_off,
  input  logic [IND_W-1:0] ind_imm,
  input  logic [XLEN-1:0]  rs1_val,
  output logic [XLEN-1:0]  seq_tgt,
  output logic [XLEN-1:0]  br_tgt,
  output logic [XLEN-1:0]  jmp_tgt,
  output logic [XLEN-1:0]  ind_tgt
);
  localparam logic [XLEN-1:0] STEP = XLEN'(4);
  localparam logic [XLEN-1:0] EVEN_MASK = ~XLEN'(1);

  // bit 0 of PC-relative offsets is architecturally zero
  logic [BR_W-1:0]  br_even;
  logic [JMP_W-1:0] jmp_even;
  logic [XLEN-1:0]  br_ext, jmp_ext, ind_ext, ind_sum;

  assign br_even  = br_off & ~BR_W'(1);
  assign jmp_even = jmp_off & ~JMP_W'(1);

  assign br_ext  = {{(XLEN-BR_W){br_even[BR_W-1]}}, br_even};
  assign jmp_ext = {{(XLEN-JMP_W){jmp_even[JMP_W-1]}}, jmp_even};
  assign ind_ext = {{(XLEN-IND_W){ind_imm[IND_W-1]}}, ind_imm};

  assign seq_tgt = pc + STEP;
  assign br_tgt  = pc + br_ext;
  assign jmp_tgt = pc + jmp_ext;
  assign ind_sum = rs1_val + ind_ext;
  assign ind_tgt = ind_sum & EVEN_MASK;
endmodule

// File: rtl/npc_select.sv
module npc_select
  import npc_pkg::*;
#(
  parameter int              XLEN      = 32,
  parameter logic [XLEN-1:0] RESET_VEC = 32'h0000_1000,
  parameter logic [XLEN-1:0] IRQ_VEC   = 32'h0000_0100
) (
  input  logic            rst,
  input  logic            irq,
  input  xfer_e           kind,
  input  logic            br_taken,
  input  logic [XLEN-1:0] seq_tgt,
  input  logic [XLEN-1:0] br_tgt,
  input  logic [XLEN-1:0] jmp_tgt,
  input  logic [XLEN-1:0] ind_tgt,
  output logic [XLEN-1:0] next_pc
);
  logic [XLEN-1:0] flow_tgt;

  always_comb begin
    unique case (kind)
      XF_BRANCH:   flow_tgt = br_taken ? br_tgt : seq_tgt;
      XF_JUMP:     flow_tgt = jmp_tgt;
      XF_INDIRECT: flow_tgt = ind_tgt;
      default:     flow_tgt = seq_tgt;
    endcase
  end

  // fixed priority: reset, then interrupt, then control flow
  always_comb begin
    if (rst)      next_pc = RESET_VEC;
    else if (irq) next_pc = IRQ_VEC;
    else          next_pc = flow_tgt;
  end
endmodule

// File: rtl/npc_link.sv
module npc_link
  import npc_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IDX_W = 5
) (
  input  logic             rst,
  input  logic             irq,
  input  xfer_e            kind,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [XLEN-1:0]  seq_tgt,
  output logic             link_we,
  output logic [XLEN-1:0]  link_val
);
  logic is_jump;

  assign is_jump  = (kind == XF_JUMP) || (kind == XF_INDIRECT);
  assign link_we  = is_jump && (rd_idx != '0) && !irq && !rst;
  assign link_val = link_we ? seq_tgt : '0;
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int              XLEN      = 32,
  parameter int              BR_W      = 13,
  parameter int              JMP_W     = 21,
  parameter int              IND_W     = 12,
  parameter int              IDX_W     = 5,
  parameter logic [XLEN-1:0] RESET_VEC = 32'h0000_1000,
  parameter logic [XLEN-1:0] IRQ_VEC   = 32'h0000_0100
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             irq,
  input  logic [1:0]       xfer_kind,
  input  logic             br_taken,
  input  logic [BR_W-1:0]  br_off,
  input  logic [JMP_W-1:0] jmp_off,
  input  logic [IND_W-1:0] ind_imm,
  input  logic [XLEN-1:0]  rs1_val,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [XLEN-1:0]  pc_q,
  output logic             link_we,
  output logic [XLEN-1:0]  link_val
);
  xfer_e           kind;
  logic [XLEN-1:0] seq_tgt, br_tgt, jmp_tgt, ind_tgt, next_pc;

  assign kind = xfer_e'(xfer_kind);

  npc_targets #(.XLEN(XLEN), .BR_W(BR_W), .JMP_W(JMP_W), .IND_W(IND_W)) u_targets (
    .pc(pc_q), .br_off(br_off), .jmp_off(jmp_off), .ind_imm(ind_imm),
    .rs1_val(rs1_val), .seq_tgt(seq_tgt), .br_tgt(br_tgt),
    .jmp_tgt(jmp_tgt), .ind_tgt(ind_tgt)
  );

  npc_select #(.XLEN(XLEN), .RESET_VEC(RESET_VEC), .IRQ_VEC(IRQ_VEC)) u_select (
    .rst(rst), .irq(irq), .kind(kind), .br_taken(br_taken),
    .seq_tgt(seq_tgt), .br_tgt(br_tgt), .jmp_tgt(jmp_tgt),
    .ind_tgt(ind_tgt), .next_pc(next_pc)
  );

  npc_link #(.XLEN(XLEN), .IDX_W(IDX_W)) u_link (
    .rst(rst), .irq(irq), .kind(kind), .rd_idx(rd_idx),
    .seq_tgt(seq_tgt), .link_we(link_we), .link_val(link_val)
  );

  always_ff @(posedge clk) begin
    pc_q <= next_pc;
  end

  // ---------------- assertions ----------------
  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  // R1: the edge after a reset cycle shows the start address
  always_ff @(posedge clk) begin
    if (rst_d) a_r1_reset_vec: assert (pc_q == RESET_VEC);
  end

  // R2
  a_r2_seq_step: assert property (@(posedge clk) disable iff (rst)
    (!irq && kind == XF_SEQ) |=> pc_q == $past(pc_q) + XLEN'(4));

  // R3
  a_r3_not_taken: assert property (@(posedge clk) disable iff (rst)
    (!irq && kind == XF_BRANCH && !br_taken) |=> pc_q == $past(pc_q) + XLEN'(4));

  // R5
  a_r5_ind_even: assert property (@(posedge clk) disable iff (rst)
    (!irq && kind == XF_INDIRECT) |=> !pc_q[0]);

  // R6
  a_r6_rd0_drop: assert property (@(posedge clk) disable iff (rst)
    (rd_idx == '0) |-> !link_we);

  // R7
  a_r7_irq_vec: assert property (@(posedge clk) disable iff (rst)
    irq |=> pc_q == IRQ_VEC);
endmodule

// File: tb/test_npc_unit.sv
module test_npc_unit;
  localparam logic [31:0] RV = 32'h0000_1000;
  localparam logic [31:0] IV = 32'h0000_0100;

  logic        clk = 1'b0;
  logic        rst, irq, br_taken;
  logic [1:0]  xfer_kind;
  logic [12:0] br_off;
  logic [20:0] jmp_off;
  logic [11:0] ind_imm;
  logic [31:0] rs1_val;
  logic [4:0]  rd_idx;
  logic [31:0] pc_q, link_val;
  logic        link_we;

  int checks = 0;
  int fails  = 0;
  logic [31:0] m_pc = 32'h0;
  bit done = 0;

  always #5 clk = ~clk;

  npc_unit i_npc_unit (
    .clk(clk), .rst(rst), .irq(irq), .xfer_kind(xfer_kind), .br_taken(br_taken),
    .br_off(br_off), .jmp_off(jmp_off), .ind_imm(ind_imm), .rs1_val(rs1_val),
    .rd_idx(rd_idx), .pc_q(pc_q), .link_we(link_we), .link_val(link_val)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one clock: drive at negedge, check link combinationally, check pc after edge
  task automatic cyc(input bit r, input bit i, input logic [1:0] k, input bit t,
                     input logic [12:0] bo, input logic [20:0] jo, input logic [11:0] im,
                     input logic [31:0] rs, input logic [4:0] rd, input string req);
    logic [31:0] exp_n, exp_lv;
    bit exp_we;
    rst = r; irq = i; xfer_kind = k; br_taken = t; br_off = bo;
    jmp_off = jo; ind_imm = im; rs1_val = rs; rd_idx = rd;
    #1;
    exp_we = !r && !i && (k >= 2'd2) && (rd != 5'd0);
    exp_lv = exp_we ? m_pc + 32'd4 : 32'd0;
    chk(link_we == exp_we, {req, " link_we"}, {31'd0, link_we}, {31'd0, exp_we});
    chk(link_val == exp_lv, {req, " link_val"}, link_val, exp_lv);
    if (r) exp_n = RV;
    else if (i) exp_n = IV;
    else begin
      case (k)
        2'd1:    exp_n = t ? m_pc + 32'($signed({bo[12:1], 1'b0})) : m_pc + 32'd4;
        2'd2:    exp_n = m_pc + 32'($signed({jo[20:1], 1'b0}));
        2'd3:    exp_n = (rs + 32'($signed(im))) & 32'hFFFF_FFFE;
        default: exp_n = m_pc + 32'd4;
      endcase
    end
    m_pc = exp_n;
    @(posedge clk);
    @(negedge clk);
    chk(pc_q == m_pc, {req, " pc"}, pc_q, m_pc);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1; irq = 0; xfer_kind = 0; br_taken = 0; br_off = 0;
    jmp_off = 0; ind_imm = 0; rs1_val = 0; rd_idx = 0;
    @(negedge clk);
    cyc(1, 0, 2'd0, 0, 0, 0, 0, 0, 0, "R1");
    cyc(1, 0, 2'd2, 0, 0, 21'h40, 0, 0, 5'd1, "R1");
    // R2 sequential, taken flag ignored
    cyc(0, 0, 2'd0, 0, 0, 0, 0, 0, 0, "R2");
    cyc(0, 0, 2'd0, 1, 13'h100, 0, 0, 0, 0, "R2");
    cyc(0, 0, 2'd0, 1, 0, 0, 0, 0, 5'd3, "R2");
    // R3 branches
    cyc(0, 0, 2'd1, 1, 13'h0010, 0, 0, 0, 5'd2, "R3");
    cyc(0, 0, 2'd1, 1, 13'h1FF0, 0, 0, 0, 0, "R3");
    cyc(0, 0, 2'd1, 1, 13'h0FFE, 0, 0, 0, 0, "R3");
    cyc(0, 0, 2'd1, 1, 13'h1000, 0, 0, 0, 0, "R3");
    cyc(0, 0, 2'd1, 1, 13'h0009, 0, 0, 0, 0, "R3");
    cyc(0, 0, 2'd1, 0, 13'h0400, 0, 0, 0, 0, "R3");
    // R4 direct jumps
    cyc(0, 0, 2'd2, 0, 0, 21'h0_1000, 0, 0, 5'd1, "R4");
    cyc(0, 0, 2'd2, 0, 0, 21'h1F_FF00, 0, 0, 5'd1, "R4");
    cyc(0, 0, 2'd2, 0, 0, 21'h0F_FFFE, 0, 0, 5'd5, "R4");
    cyc(0, 0, 2'd2, 0, 0, 21'h10_0000, 0, 0, 5'd0, "R4");
    cyc(0, 0, 2'd2, 0, 0, 21'h0_0011, 0, 0, 5'd31, "R4");
    // R5 indirect
    cyc(0, 0, 2'd3, 0, 0, 0, 12'h010, 32'h0000_2000, 5'd1, "R5");
    cyc(0, 0, 2'd3, 0, 0, 0, 12'hFFF, 32'h0000_4000, 5'd1, "R5");
    cyc(0, 0, 2'd3, 0, 0, 0, 12'h800, 32'h0001_0001, 5'd0, "R5");
    cyc(0, 0, 2'd3, 0, 0, 0, 12'h003, 32'h0000_8000, 5'd7, "R5");
    // R6 link discarded for rd zero, absent for non-jumps
    cyc(0, 0, 2'd2, 0, 0, 21'h20, 0, 0, 5'd0, "R6");
    cyc(0, 0, 2'd1, 1, 13'h20, 0, 0, 0, 5'd4, "R6");
    cyc(0, 0, 2'd3, 0, 0, 0, 12'h0, 32'h3000, 5'd9, "R6");
    // R7 interrupt overrides transfer and link
    cyc(0, 1, 2'd2, 0, 0, 21'h400, 0, 0, 5'd1, "R7");
    cyc(0, 0, 2'd0, 0, 0, 0, 0, 0, 0, "R7");
    cyc(0, 1, 2'd3, 0, 0, 0, 12'h10, 32'h5000, 5'd1, "R7");
    // R8 reset beats interrupt
    cyc(1, 1, 2'd2, 0, 0, 21'h400, 0, 0, 5'd1, "R8");
    // R9 wrap
    cyc(0, 0, 2'd3, 0, 0, 0, 12'h000, 32'hFFFF_FFFC, 5'd0, "R9");
    cyc(0, 0, 2'd0, 0, 0, 0, 0, 0, 0, "R9");
    cyc(0, 0, 2'd1, 1, 13'h1FFC, 0, 0, 0, 0, "R9");
    // random stream
    for (int n = 0; n < 400; n++) begin
      cyc(($urandom % 40) == 0, ($urandom % 12) == 0, 2'($urandom), 1'($urandom),
          13'($urandom), 21'($urandom), 12'($urandom), $urandom, 5'($urandom), "R2..R8 random");
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule